// File: doc/BRIEF.md
# PLL Reconfiguration Command Port

This block is the target side of a management port that changes a PLL's settings while the PLL is running. A host writes address/data commands, each as a write strobe held for one clock cycle. The block does not apply them at once. It queues up to eight commands in a small FIFO, and a later write to address zero launches a batch apply.

During the apply phase the block holds its waitrequest output high. It drains the queue into a file of shadow registers, one command per clock. Each command is classified as one of three kinds: a counter setting, a bandwidth setting (charge pump or loop filter), or a phase-shift step. After the queue is empty, the block waits a programmable number of extra cycles, which stands in for the analog settling and lock time. Only then does waitrequest drop.

A ninth command written before a start is dropped and sets a sticky overflow flag. A command whose address matches no known setting changes no shadow register and is counted in a small saturating counter.

Top module: `pll_cmd_port`

## Requirements
- R1: A write is accepted when `mgmt_write` is high in a cycle where `mgmt_waitrequest` is low. An accepted write to a nonzero address is appended to the command queue.
- R2: The queue holds at most DEPTH (default 8) commands. A command written while the queue is full is dropped and never applied.
- R3: Dropping a command sets `overflow_err`. The flag stays set through later batches and is cleared only by reset.
- R4: An accepted write to address 0x000 is a start command. Its data is ignored, it is not queued, and `mgmt_waitrequest` is high from the next cycle on.
- R5: During the apply phase the queued commands are applied in the order they were written, one per cycle. When two commands target the same setting, the later one wins.
- R6: For a batch of N queued commands and an `apply_delay` of D, `mgmt_waitrequest` stays high for exactly N+1+D cycles and then falls. At that point every applied value is visible on the outputs.
- R7: Counter and bandwidth decoding follows this map. Address 0x090 sets `m_val`, 0x0A0 sets `n_val`, 0x0C0+i sets `c_val[i]` for i < NUM_OUT, 0x020 sets `cp_val` and 0x040 sets `lf_val`. Each write stores the full 32-bit data word.
- R8: A command at address 0x060 is a phase-shift step. It loads `phase_word` with its data and raises `phase_strobe` for the cycle after it is applied. No other setting changes.
- R9: A command at any other nonzero address leaves every setting unchanged. It increments `unk_count`, which saturates at its all-ones value.
- R10: Writes presented while `mgmt_waitrequest` is high are not accepted. They are not queued, and a start written then does not lengthen or restart the apply phase.
- R11: Reset empties the queue and drives `mgmt_waitrequest`, `overflow_err`, `phase_strobe`, `unk_count` and all shadow settings to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_write | input | 1 | Write strobe, one cycle per command |
| mgmt_address | input | 9 | Command address; 0x000 starts a batch |
| mgmt_writedata | input | 32 | Command data |
| apply_delay | input | DELAY_W | Extra cycles of waitrequest after the queue is drained |
| mgmt_waitrequest | output | 1 | High during the apply phase; writes are stalled |
| overflow_err | output | 1 | Sticky flag: a command was dropped on a full queue |
| unk_count | output | UNK_W | Saturating count of commands with unknown addresses |
| m_val | output | 32 | Shadow feedback (M) counter setting |
| n_val | output | 32 | Shadow pre-divide (N) counter setting |
| c_val | output | NUM_OUT x 32 | Shadow output counter settings, one per output |
| cp_val | output | 32 | Shadow charge-pump setting |
| lf_val | output | 32 | Shadow loop-filter setting |
| phase_word | output | 32 | Data of the last applied phase-shift step |
| phase_strobe | output | 1 | One-cycle pulse per applied phase-shift step |

## Verification
The bench keeps the default queue depth of 8, three output counters and an 8-bit delay field. It narrows `unk_count` to 2 bits, so that saturation is reached after three unknown commands instead of hundreds. With three outputs, address 0x0C3 lies just past the last output counter and serves as a boundary unknown address. The 8-bit delay allows both a zero delay and a long apply phase of 20 cycles. The long phase leaves room to present stalled writes and a stalled start while waitrequest is still high.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_START  = 9'h000;
    localparam logic [ADDR_W-1:0] A_CP     = 9'h020;
    localparam logic [ADDR_W-1:0] A_LF     = 9'h040;
    localparam logic [ADDR_W-1:0] A_PHASE  = 9'h060;
    localparam logic [ADDR_W-1:0] A_M      = 9'h090;
    localparam logic [ADDR_W-1:0] A_N      = 9'h0A0;
    localparam logic [ADDR_W-1:0] A_C_BASE = 9'h0C0;

    typedef enum logic [1:0] {K_NONE, K_COUNTER, K_BANDWIDTH, K_PHASE} kind_e;
    typedef enum logic [2:0] {T_NONE, T_M, T_N, T_C, T_CP, T_LF, T_PH} tgt_e;
    typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_HOLD} apply_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        kind_e      kind;
        tgt_e       tgt;
        logic [3:0] cidx;
    } dec_t;

    // Classify a queued command by its address.
    function automatic dec_t decode_cmd(input logic [ADDR_W-1:0] a, input int num_out);
        dec_t             d;
        logic [ADDR_W-1:0] off;
        d.kind = K_NONE;
        d.tgt  = T_NONE;
        d.cidx = '0;
        off    = a - A_C_BASE;
        if (a == A_M) begin
            d.kind = K_COUNTER;
            d.tgt  = T_M;
        end else if (a == A_N) begin
            d.kind = K_COUNTER;
            d.tgt  = T_N;
        end else if (a >= A_C_BASE && a < A_C_BASE + ADDR_W'(num_out)) begin
            d.kind = K_COUNTER;
            d.tgt  = T_C;
            d.cidx = off[3:0];
        end else if (a == A_CP) begin
            d.kind = K_BANDWIDTH;
            d.tgt  = T_CP;
        end else if (a == A_LF) begin
            d.kind = K_BANDWIDTH;
            d.tgt  = T_LF;
        end else if (a == A_PHASE) begin
            d.kind = K_PHASE;
            d.tgt  = T_PH;
        end
        return d;
    endfunction

endpackage

// File: rtl/pll_cmd_fifo.sv
module pll_cmd_fifo
    import pllcfg_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  cmd_t             din,
    input  logic             pop,
    output cmd_t             dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    cmd_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pll_apply_ctrl.sv
module pll_apply_ctrl
    import pllcfg_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               empty,
    input  logic [DELAY_W-1:0] apply_delay,
    output logic               busy,
    output logic               pop
);

    apply_st_e          st;
    logic [DELAY_W-1:0] hold_cnt;

    assign busy = (st != S_IDLE);
    assign pop  = (st == S_DRAIN) && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            hold_cnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) st <= S_DRAIN;
                end
                S_DRAIN: begin
                    if (empty) begin
                        if (apply_delay == '0) begin
                            st <= S_IDLE;
                        end else begin
                            st       <= S_HOLD;
                            hold_cnt <= apply_delay;
                        end
                    end
                end
                S_HOLD: begin
                    if (hold_cnt == DELAY_W'(1)) st <= S_IDLE;
                    else                         hold_cnt <= hold_cnt - 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs
    import pllcfg_pkg::*;
#(
    parameter int NUM_OUT = 3,
    parameter int UNK_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            apply,
    input  cmd_t                            cmd,
    output logic [DATA_W-1:0]               m_val,
    output logic [DATA_W-1:0]               n_val,
    output logic [NUM_OUT-1:0][DATA_W-1:0]  c_val,
    output logic [DATA_W-1:0]               cp_val,
    output logic [DATA_W-1:0]               lf_val,
    output logic [DATA_W-1:0]               phase_word,
    output logic                            phase_strobe,
    output logic [UNK_W-1:0]                unk_count
);

    dec_t dec;
    assign dec = decode_cmd(cmd.addr, NUM_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_val        <= '0;
            n_val        <= '0;
            cp_val       <= '0;
            lf_val       <= '0;
            phase_word   <= '0;
            phase_strobe <= 1'b0;
            unk_count    <= '0;
        end else begin
            phase_strobe <= 1'b0;
            if (apply) begin
                case (dec.tgt)
                    T_M:  m_val  <= cmd.data;
                    T_N:  n_val  <= cmd.data;
                    T_CP: cp_val <= cmd.data;
                    T_LF: lf_val <= cmd.data;
                    T_PH: begin
                        phase_word   <= cmd.data;
                        phase_strobe <= 1'b1;
                    end
                    default: ;
                endcase
                if (dec.kind == K_NONE && unk_count != '1) begin
                    unk_count <= unk_count + 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                c_val[i] <= '0;
            end else if (apply && dec.tgt == T_C && dec.cidx == 4'(i)) begin
                c_val[i] <= cmd.data;
            end
        end
    end

endmodule

// File: rtl/pll_cmd_port.sv
module pll_cmd_port
    import pllcfg_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int NUM_OUT = 3,
    parameter int DELAY_W = 8,
    parameter int UNK_W   = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            mgmt_write,
    input  logic [8:0]                      mgmt_address,
    input  logic [31:0]                     mgmt_writedata,
    input  logic [DELAY_W-1:0]              apply_delay,
    output logic                            mgmt_waitrequest,
    output logic                            overflow_err,
    output logic [UNK_W-1:0]                unk_count,
    output logic [31:0]                     m_val,
    output logic [31:0]                     n_val,
    output logic [NUM_OUT-1:0][31:0]        c_val,
    output logic [31:0]                     cp_val,
    output logic [31:0]                     lf_val,
    output logic [31:0]                     phase_word,
    output logic                            phase_strobe
);

    logic             accept;
    logic             is_start;
    logic             q_push;
    logic             q_pop;
    logic             q_empty;
    logic             q_full;
    logic [CNT_W-1:0] q_count;
    cmd_t             q_in;
    cmd_t             q_out;
    logic             busy;

    assign accept   = mgmt_write && !busy;
    assign is_start = accept && (mgmt_address == A_START);
    assign q_push   = accept && !is_start;
    assign q_in     = '{addr: mgmt_address, data: mgmt_writedata};

    assign mgmt_waitrequest = busy;

    pll_cmd_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (q_in),
        .pop   (q_pop),
        .dout  (q_out),
        .empty (q_empty),
        .full  (q_full),
        .count (q_count)
    );

    pll_apply_ctrl #(.DELAY_W(DELAY_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start       (is_start),
        .empty       (q_empty),
        .apply_delay (apply_delay),
        .busy        (busy),
        .pop         (q_pop)
    );

    pll_shadow_regs #(.NUM_OUT(NUM_OUT), .UNK_W(UNK_W)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .apply        (q_pop),
        .cmd          (q_out),
        .m_val        (m_val),
        .n_val        (n_val),
        .c_val        (c_val),
        .cp_val       (cp_val),
        .lf_val       (lf_val),
        .phase_word   (phase_word),
        .phase_strobe (phase_strobe),
        .unk_count    (unk_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow_err <= 1'b0;
        end else if (q_push && q_full) begin
            overflow_err <= 1'b1;
        end
    end

endmodule

// File: rtl/pll_cmd_port_chk.sv
module pll_cmd_port_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mgmt_write,
    input logic [8:0]       mgmt_address,
    input logic             mgmt_waitrequest,
    input logic             overflow_err,
    input logic [CNT_W-1:0] q_count,
    input logic             q_empty,
    input logic             q_pop,
    input logic             phase_strobe
);

    p_queue_bound_r2: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    p_overflow_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_err) |-> $past(mgmt_write && !mgmt_waitrequest &&
                                      mgmt_address != 9'h000 && q_count == CNT_W'(DEPTH)));

    p_start_launch_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mgmt_waitrequest) |-> $past(mgmt_write && mgmt_address == 9'h000));

    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (mgmt_write && !mgmt_waitrequest && mgmt_address == 9'h000) |=> mgmt_waitrequest);

    p_pop_in_apply_r5: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> mgmt_waitrequest);

    p_done_drained_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(mgmt_waitrequest) |-> q_empty);

    p_phase_follows_pop_r8: assert property (@(posedge clk) disable iff (rst)
        phase_strobe |-> $past(q_pop));

    p_stall_no_growth_r10: assert property (@(posedge clk) disable iff (rst)
        mgmt_waitrequest |=> q_count <= $past(q_count));

endmodule

bind pll_cmd_port pll_cmd_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .mgmt_write       (mgmt_write),
    .mgmt_address     (mgmt_address),
    .mgmt_waitrequest (mgmt_waitrequest),
    .overflow_err     (overflow_err),
    .q_count          (q_count),
    .q_empty          (q_empty),
    .q_pop            (q_pop),
    .phase_strobe     (phase_strobe)
);

// File: tb/pll_cmd_port_tb_top.sv
module pll_cmd_port_tb_top;
    import pllcfg_pkg::*;

    localparam int DEPTH   = 8;
    localparam int NUM_OUT = 3;
    localparam int DELAY_W = 8;
    localparam int UNK_W   = 2;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     mgmt_write;
    logic [8:0]               mgmt_address;
    logic [31:0]              mgmt_writedata;
    logic [DELAY_W-1:0]       apply_delay;
    logic                     mgmt_waitrequest;
    logic                     overflow_err;
    logic [UNK_W-1:0]         unk_count;
    logic [31:0]              m_val, n_val, cp_val, lf_val, phase_word;
    logic [NUM_OUT-1:0][31:0] c_val;
    logic                     phase_strobe;

    always #2 clk = ~clk;

    pll_cmd_port #(.DEPTH(DEPTH), .NUM_OUT(NUM_OUT), .DELAY_W(DELAY_W), .UNK_W(UNK_W)) dut_i (
        .clk(clk), .rst(rst), .mgmt_write(mgmt_write), .mgmt_address(mgmt_address),
        .mgmt_writedata(mgmt_writedata), .apply_delay(apply_delay),
        .mgmt_waitrequest(mgmt_waitrequest), .overflow_err(overflow_err),
        .unk_count(unk_count), .m_val(m_val), .n_val(n_val), .c_val(c_val),
        .cp_val(cp_val), .lf_val(lf_val), .phase_word(phase_word),
        .phase_strobe(phase_strobe)
    );

    int          checks = 0;
    int          errors = 0;
    int          exp_len_q[$];
    logic [31:0] exp_ph_q[$];
    int          run_len = 0;

    task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor: busy-window lengths and phase-step words.
    always @(negedge clk) begin
        if (rst) begin
            run_len = 0;
        end else begin
            if (mgmt_waitrequest) begin
                run_len++;
            end else if (run_len > 0) begin
                if (exp_len_q.size() == 0) begin
                    check32("R6", "unexpected busy window", run_len, 0);
                end else begin
                    check32("R6", "busy length", run_len, exp_len_q.pop_front());
                end
                run_len = 0;
            end
            if (phase_strobe) begin
                if (exp_ph_q.size() == 0) check32("R8", "unexpected phase strobe", phase_word, 0);
                else                      check32("R8", "phase word", phase_word, exp_ph_q.pop_front());
            end
        end
    end

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        mgmt_write     = 1'b1;
        mgmt_address   = a;
        mgmt_writedata = d;
        @(negedge clk);
        mgmt_write     = 1'b0;
    endtask

    task automatic push_phase(logic [31:0] d);
        exp_ph_q.push_back(d);
        wr(A_PHASE, d);
    endtask

    task automatic issue_start(int n, int d);
        apply_delay = DELAY_W'(d);
        exp_len_q.push_back(n + 1 + d);
        wr(A_START, 32'hFFFF_FFFF);
        check32("R4", "waitrequest after start", 32'(mgmt_waitrequest), 1);
    endtask

    task automatic wait_idle();
        while (mgmt_waitrequest) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst            = 1'b1;
        mgmt_write     = 1'b0;
        mgmt_address   = '0;
        mgmt_writedata = '0;
        apply_delay    = '0;
        repeat (3) @(negedge clk);
        check32("R11", "waitrequest in reset", 32'(mgmt_waitrequest), 0);
        check32("R11", "overflow in reset", 32'(overflow_err), 0);
        check32("R11", "m_val in reset", m_val, 0);
        check32("R11", "unk_count in reset", 32'(unk_count), 0);
        rst = 1'b0;

        // R1 / R7: full map load, delay 3
        wr(A_M, 32'h0000_0F0F);
        wr(A_N, 32'h0001_0000);
        wr(A_C_BASE + 9'd0, 32'h0000_0303);
        wr(A_C_BASE + 9'd1, 32'h0000_1E1E);
        wr(A_C_BASE + 9'd2, 32'h0000_2625);
        wr(A_CP, 32'h0000_0010);
        wr(A_LF, 32'h0000_0100);
        check32("R1", "settings untouched before start", m_val, 0);
        issue_start(7, 3);
        wait_idle();
        check32("R7", "m_val", m_val, 32'h0000_0F0F);
        check32("R7", "n_val", n_val, 32'h0001_0000);
        check32("R7", "c_val0", c_val[0], 32'h0000_0303);
        check32("R7", "c_val1", c_val[1], 32'h0000_1E1E);
        check32("R7", "c_val2", c_val[2], 32'h0000_2625);
        check32("R7", "cp_val", cp_val, 32'h0000_0010);
        check32("R7", "lf_val", lf_val, 32'h0000_0100);
        check32("R2", "no overflow for 7", 32'(overflow_err), 0);

        // R5: order, last write wins
        wr(A_M, 32'h11);
        wr(A_M, 32'h22);
        wr(A_C_BASE + 9'd1, 32'h33);
        issue_start(3, 0);
        wait_idle();
        check32("R5", "m_val last wins", m_val, 32'h22);
        check32("R5", "c_val1", c_val[1], 32'h33);
        check32("R5", "n_val kept", n_val, 32'h0001_0000);

        // R8: phase steps
        push_phase(32'h5);
        push_phase(32'h7);
        issue_start(2, 1);
        wait_idle();
        check32("R8", "m_val unchanged by phase", m_val, 32'h22);
        check32("R8", "final phase word", phase_word, 32'h7);
        check32("R8", "all strobes seen", exp_ph_q.size(), 0);

        // R9: unknown addresses, saturation at 3
        wr(9'h155, 32'h1);
        wr(A_C_BASE + 9'd3, 32'h2);
        issue_start(2, 0);
        wait_idle();
        check32("R9", "unk_count 2", 32'(unk_count), 2);
        check32("R9", "c_val2 kept", c_val[2], 32'h0000_2625);
        wr(9'h001, 32'h3);
        wr(9'h1FF, 32'h4);
        wr(9'h091, 32'h5);
        issue_start(3, 0);
        wait_idle();
        check32("R9", "unk_count saturated", 32'(unk_count), 3);
        check32("R9", "m_val kept", m_val, 32'h22);

        // R2 / R3: overflow
        for (int i = 1; i <= 8; i++) wr(A_M, 32'(i));
        check32("R2", "no overflow at 8", 32'(overflow_err), 0);
        wr(A_N, 32'hAA);
        check32("R3", "overflow on 9th", 32'(overflow_err), 1);
        issue_start(8, 2);
        wait_idle();
        check32("R2", "m_val from 8th", m_val, 32'h8);
        check32("R2", "9th dropped", n_val, 32'h0001_0000);
        wr(A_CP, 32'h0B);
        issue_start(1, 0);
        wait_idle();
        check32("R3", "overflow sticky", 32'(overflow_err), 1);
        check32("R3", "clean batch applied", cp_val, 32'h0B);

        // R10: stalled writes
        issue_start(0, 20);
        wr(A_M, 32'hDEAD);
        wr(A_START, 32'h0);
        check32("R10", "still busy", 32'(mgmt_waitrequest), 1);
        wait_idle();
        issue_start(0, 0);
        wait_idle();
        @(negedge clk);
        check32("R10", "stalled write not queued", m_val, 32'h8);
        check32("R10", "all windows seen", exp_len_q.size(), 0);

        // R11: reset mid-life
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check32("R11", "overflow cleared", 32'(overflow_err), 0);
        check32("R11", "m_val cleared", m_val, 0);
        check32("R11", "unk cleared", 32'(unk_count), 0);
        check32("R11", "waitrequest low", 32'(mgmt_waitrequest), 0);
        issue_start(0, 0);
        wait_idle();
        @(negedge clk);
        check32("R11", "queue empty after reset", m_val, 0);
        check32("R11", "window after reset", exp_len_q.size(), 0);

        finish_run();
    end

endmodule